// File: doc/BRIEF.md
# Processor Ready-Line Stall and Instruction-Step Controller

This block drives the ready input of an 8-bit processor bus. The processor only acts on a low ready line during read cycles. It then freezes with its address outputs still showing the location being fetched, and it resumes once ready goes high again. The controller uses that behaviour for three purposes:

- stretching accesses to slow memory;
- opening short direct-memory-access windows while the processor is frozen;
- running a program one instruction at a time under control of a push button or a debugger.

Stepping follows the processor's opcode-fetch indicator rather than a cycle count. With step mode on, ready drops in every cycle that is an opcode fetch. Each clean press of the step input lets exactly one instruction through: the pending fetch finishes, the instruction executes, and ready drops again at the next opcode fetch. A halted flag reports the cycles in which the processor is actually frozen. A grant output hands the bus to a memory-access master for no more than a fixed number of frozen cycles per request.

Top module: `rdy_ctrl`

## Requirements
- R1: After reset, ready is high, halted is low and grant is low, and the stepper waits for a press before letting any opcode fetch complete.
- R2: With step mode off, the opcode-fetch indicator has no effect: ready is low exactly when wait_req_i or an active memory-access stall is present.
- R3: With step mode on and no press pending, ready is low in every cycle where sync_i is 1 (an opcode fetch).
- R4: A step press is synchronised through two flip-flops and edge-detected. A rising edge sampled at clock edge k releases ready from the cycle after edge k+2. Ready stays high through the completion of the pending fetch (sync_i=1 with ready high) and until the next cycle with sync_i=1, where it drops again.
- R5: Holding the step input high advances only one instruction. A further advance needs the input to go low and rise again.
- R6: wait_req_i=1 drives ready low in the same cycle. A fetch stalled this way does not count as the completed fetch of a step.
- R7: halted_o is 1 exactly when ready is low and rnw_i=1 (a read cycle). On write cycles (rnw_i=0) halted_o is 0 whatever ready does.
- R8: dma_req_i=1 pulls ready low. dma_grant_o is 1 only in cycles where halted_o is 1.
- R9: Per request, dma_grant_o is 1 in at most DMA_MAX (default 2) cycles. After that the request no longer stalls the processor or receives a grant until dma_req_i has returned to 0.
- R10: A press that arrives while the stepper is already releasing an instruction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor cycle clock, one rising edge per bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Opcode-fetch indicator from the processor |
| rnw_i | input | 1 | Bus direction, 1 = read, 0 = write |
| step_mode_i | input | 1 | 1 = single-instruction stepping enabled |
| step_btn_i | input | 1 | Asynchronous step press from a user or debugger |
| wait_req_i | input | 1 | Slow-memory wait request |
| dma_req_i | input | 1 | Memory-access master requests the bus |
| rdy_o | output | 1 | Ready line to the processor |
| halted_o | output | 1 | Processor frozen in this cycle |
| dma_grant_o | output | 1 | Bus granted to the memory-access master this cycle |

## Verification
Ready, halted and grant are combinational from sync_i, rnw_i, wait_req_i and dma_req_i in the same cycle, so the bench drives inputs just after the falling edge and compares outputs shortly before the next rising edge. A step press first affects ready in the cycle after the second rising edge that follows the sampled edge, and the grant budget changes only at rising edges. The bench's reference state advances at each rising edge using the values it predicted for that cycle, so every comparison falls in the cycle the requirements place it.

// File: rtl/rdy_ctrl_pkg.sv
package rdy_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,   // next opcode fetch is stopped
    ST_FETCH = 2'd1,   // pending fetch may complete
    ST_EXEC  = 2'd2    // instruction running until next fetch
  } step_st_e;

  // Ready is released only when no source asks for a stall.
  function automatic logic rdy_level(input logic step_hold,
                                     input logic wait_req,
                                     input logic dma_stall);
    return !(step_hold || wait_req || dma_stall);
  endfunction

  // A low ready only freezes the processor on a read cycle.
  function automatic logic frozen(input logic rdy, input logic rnw);
    return !rdy && rnw;
  endfunction

endpackage

// File: rtl/rdy_step_sync.sv
module rdy_step_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic pulse_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= btn_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign pulse_o = chain[STAGES-1] && !last_q;
endmodule

// File: rtl/rdy_step_fsm.sv
module rdy_step_fsm
  import rdy_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step_mode_i,
  input  logic     sync_i,
  input  logic     rdy_i,
  input  logic     pulse_i,
  output logic     step_hold_o,
  output step_st_e state_o
);
  step_st_e st_q, st_d;
  logic     fetch_done;

  assign fetch_done = sync_i && rdy_i;

  always_comb begin
    st_d = st_q;
    if (!step_mode_i) st_d = ST_HOLD;
    else begin
      unique case (st_q)
        ST_HOLD:  if (pulse_i)    st_d = ST_FETCH;
        ST_FETCH: if (fetch_done) st_d = ST_EXEC;
        ST_EXEC:  if (sync_i)     st_d = ST_HOLD;
        default:                  st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_HOLD;
    else        st_q <= st_d;
  end

  assign step_hold_o = step_mode_i && sync_i && (st_q != ST_FETCH);
  assign state_o     = st_q;

  assert_fetch_from_press_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && $past(st_q) != ST_FETCH) |-> $past(pulse_i));

  assert_exec_after_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC && $past(st_q) == ST_FETCH) |-> $past(sync_i && rdy_i));
endmodule

// File: rtl/rdy_dma_limit.sv
module rdy_dma_limit #(
  parameter int DMA_MAX = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic halted_i,
  output logic stall_o,
  output logic grant_o
);
  localparam int CW = $clog2(DMA_MAX + 1);

  logic [CW-1:0] used_q;
  logic          spent;

  assign spent   = (used_q == CW'(DMA_MAX));
  assign stall_o = req_i && !spent;
  assign grant_o = stall_o && halted_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       used_q <= '0;
    else if (!req_i)  used_q <= '0;
    else if (grant_o) used_q <= used_q + 1'b1;
  end

  // Independent window counter: grants seen since the request rose.
  logic [7:0] seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !req_i)          seen_q <= '0;
    else if (grant_o && seen_q != 8'hFF) seen_q <= seen_q + 1'b1;
  end

  assert_grant_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (32'(seen_q) < DMA_MAX));
endmodule

// File: rtl/rdy_ctrl.sv
module rdy_ctrl
  import rdy_ctrl_pkg::*;
#(
  parameter int BTN_STAGES = 2,
  parameter int DMA_MAX    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic rnw_i,
  input  logic step_mode_i,
  input  logic step_btn_i,
  input  logic wait_req_i,
  input  logic dma_req_i,
  output logic rdy_o,
  output logic halted_o,
  output logic dma_grant_o
);
  logic     step_pulse;
  logic     step_hold;
  logic     dma_stall;
  step_st_e step_state;

  rdy_step_sync #(.STAGES(BTN_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_i   (step_btn_i),
    .pulse_o (step_pulse)
  );

  rdy_step_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_mode_i (step_mode_i),
    .sync_i      (sync_i),
    .rdy_i       (rdy_o),
    .pulse_i     (step_pulse),
    .step_hold_o (step_hold),
    .state_o     (step_state)
  );

  rdy_dma_limit #(.DMA_MAX(DMA_MAX)) u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (dma_req_i),
    .halted_i (halted_o),
    .stall_o  (dma_stall),
    .grant_o  (dma_grant_o)
  );

  assign rdy_o    = rdy_level(step_hold, wait_req_i, dma_stall);
  assign halted_o = frozen(rdy_o, rnw_i);

  assert_grant_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_grant_o |-> (!rdy_o && rnw_i));

  assert_fetch_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_mode_i && sync_i && step_state == ST_HOLD) |-> !rdy_o);
endmodule

// File: tb/sim_rdy_ctrl.sv
module sim_rdy_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 0, rnw_i = 1, step_mode_i = 0, step_btn_i = 0;
  logic wait_req_i = 0, dma_req_i = 0;
  logic rdy_o, halted_o, dma_grant_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  rdy_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .rnw_i(rnw_i),
    .step_mode_i(step_mode_i), .step_btn_i(step_btn_i),
    .wait_req_i(wait_req_i), .dma_req_i(dma_req_i),
    .rdy_o(rdy_o), .halted_o(halted_o), .dma_grant_o(dma_grant_o)
  );

  // Reference state: button pipe, step phase (0 stop,1 pass fetch,2 run), grant budget
  logic b1 = 0, b2 = 0, b3 = 0;
  int   phase = 0;
  int   used  = 0;
  localparam int BUDGET = 2;

  function automatic logic want_rdy(input logic s, input logic m, input logic w,
                                    input logic d, input int ph, input int u);
    logic hold_fetch = m && s && (ph != 1);
    logic dma_pull   = d && (u < BUDGET);
    return !(hold_fetch || w || dma_pull);
  endfunction

  task automatic cmp(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic s, input logic r, input logic m,
                       input logic b, input logic w, input logic d);
    logic er, eh, eg;
    string tr;
    @(negedge clk);
    #1;
    sync_i = s; rnw_i = s ? 1'b1 : r; step_mode_i = m;
    step_btn_i = b; wait_req_i = w; dma_req_i = d;
    #2;
    er = want_rdy(sync_i, m, w, d, phase, used);
    eh = !er && rnw_i;
    eg = d && (used < BUDGET) && eh;
    tr = w ? "R6" : (d ? "R8" : (m ? "R3" : "R2"));
    if (m && phase != 0) tr = "R4";
    cmp(rdy_o, er, tr);
    cmp(halted_o, eh, "R7");
    cmp(dma_grant_o, eg, "R9");
    @(posedge clk);
    if (!m) phase = 0;
    else if (phase == 0) begin if (b2 && !b3) phase = 1; end
    else if (phase == 1) begin if (sync_i && er) phase = 2; end
    else if (sync_i) phase = 0;
    if (!d) used = 0; else if (eg) used++;
    b3 = b2; b2 = b1; b1 = b;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed = 17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #3;
    // R1: reset state
    cmp(rdy_o, 1'b1, "R1");
    cmp(halted_o, 1'b0, "R1");
    cmp(dma_grant_o, 1'b0, "R1");

    // R2: step mode off, sync ignored
    repeat (4) cycle(1, 1, 0, 0, 0, 0);
    // R3: step mode on, fetch stopped, no press
    repeat (4) cycle(1, 1, 1, 0, 0, 0);
    // R4 and R5: press held high, fetch pending, then instruction body, next fetch
    repeat (6) cycle(1, 1, 1, 1, 0, 0);
    repeat (3) cycle(0, 1, 1, 1, 0, 0);
    repeat (3) cycle(1, 1, 1, 1, 0, 0);   // R5: still stopped while held
    // R10: second press while running is ignored
    repeat (3) cycle(1, 1, 1, 0, 0, 0);
    repeat (3) cycle(1, 1, 1, 1, 0, 0);
    repeat (2) cycle(0, 0, 1, 1, 0, 0);
    repeat (2) cycle(0, 1, 1, 0, 0, 0);
    repeat (3) cycle(0, 1, 1, 1, 0, 0);   // R10 press during run
    repeat (3) cycle(1, 1, 1, 1, 0, 0);
    // R6: wait during a released fetch keeps it pending
    repeat (2) cycle(1, 1, 1, 0, 0, 0);
    repeat (3) cycle(1, 1, 1, 1, 1, 0);
    repeat (2) cycle(1, 1, 1, 1, 0, 0);
    // R7: write cycle with wait does not halt
    repeat (3) cycle(0, 0, 0, 0, 1, 0);
    // R8 and R9: request across a write, then budget runs out
    cycle(0, 0, 0, 0, 0, 1);
    repeat (5) cycle(0, 1, 0, 0, 0, 1);
    cycle(0, 1, 0, 0, 0, 0);
    repeat (3) cycle(0, 1, 0, 0, 0, 1);

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic s, r, m, w, d;
      logic b;
      s = ($urandom % 4) == 0;
      r = ($urandom % 5) != 0;
      m = ((i / 400) % 3) != 2;
      b = ((i / 7) % 3) == 0 && ($urandom % 8) != 0;
      w = ($urandom % 10) == 0;
      d = ((i / 13) % 4) == 1;
      cycle(s, r, m, b, w, d);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule